// File: doc/BRIEF.md
# Key-Sequence Watchdog with Reset Pulse

This block is a watchdog timer that software turns on by writing a two-byte key to one address on a simple register write bus. After a hardware reset it is inactive and cannot fire. The key is 0x1E followed by 0xE1, both written to address 0xA6. Once the key is accepted, a 14-bit counter advances on every machine-cycle enable. Only a hardware reset or the watchdog's own expiry stops it. Writing the same key again while it runs returns the count to zero, and this is how software services the watchdog.

When the counter runs past its top value, the watchdog returns to its inactive state and drives a reset output high for 98 oscillator clock cycles. A static inhibit input, the disable bit of an auxiliary control register held elsewhere, suppresses that pulse. The inhibit input is low by default, so the pulse is enabled unless software sets the bit. The analog drive of the reset pin is outside this block.

Top module: `armed_watchdog`

## Requirements
- R1: After a hardware reset the watchdog is inactive. `rst_out_o` stays low and no pulse appears however many machine cycles pass.
- R2: A write of 0x1E to address 0xA6 followed by a write of 0xE1 to address 0xA6 activates the watchdog. Writes to other addresses between the two bytes do not disturb the key.
- R3: An active watchdog counts from zero by one per cycle with `mc_en_i` high. The 16384th enabled cycle after activation is the expiry. `rst_out_o` goes high on the clock edge of that cycle.
- R4: Any write to 0xA6 between the two key bytes other than 0xE1 aborts the key, and 0x1E must then be written again. A lone 0xE1 has no effect.
- R5: A reset pulse stays high for exactly 98 consecutive clock cycles.
- R6: Expiry clears the count and makes the watchdog inactive, so no further pulse occurs unless the key is written again.
- R7: Writing the key while the watchdog is active restarts the count from zero. The next expiry is then 16384 enabled cycles after the second key byte.
- R8: While `mc_en_i` is low the count holds its value.
- R9: If `rst_out_inhibit_i` is high at expiry, no pulse is produced.
- R10: A hardware reset makes an active watchdog inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Hardware reset, active low, asynchronous assert |
| mc_en_i | input | 1 | Machine-cycle enable, one clock wide per machine cycle |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register write address |
| bus_wdata_i | input | 8 | Register write data |
| rst_out_inhibit_i | input | 1 | High suppresses the reset pulse on expiry |
| rst_out_o | output | 1 | Reset pulse, high for 98 clocks after expiry |

## Verification
The bound checker follows the internal key-accept strobe, the active flag, the count and the expiry strobe on every cycle. It checks that activation always traces back to an accepted key, that the count steps by one or holds with the enable, that a key or an expiry leaves the count at zero, and that every pulse is caused by an uninhibited expiry and lasts 98 clocks. The exact expiry distance of 16384 enabled cycles, the abort of a broken key, and the silence after expiry, after a reset or under inhibit can only be shown end to end. The directed scenarios in the bench cover these, measuring cycle counts at the reset output.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // Key detector state: waiting for the first byte or the second.
  typedef enum logic {
    KEY_WAIT_FIRST  = 1'b0,
    KEY_WAIT_SECOND = 1'b1
  } key_state_e;
endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/wdg_unlock.sv
module wdg_unlock
  import wdg_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clear_i,
  output logic              kick_o
);
  key_state_e state_q, state_d;
  logic       hit;

  assign hit    = wr_i && (addr_i == KEY_ADDR);
  assign kick_o = hit && (state_q == KEY_WAIT_SECOND) && (data_i == KEY_SECOND);

  always_comb begin
    state_d = state_q;
    if (clear_i) begin
      state_d = KEY_WAIT_FIRST;
    end else if (hit) begin
      unique case (state_q)
        KEY_WAIT_FIRST:  state_d = (data_i == KEY_FIRST) ? KEY_WAIT_SECOND : KEY_WAIT_FIRST;
        KEY_WAIT_SECOND: state_d = KEY_WAIT_FIRST;
        default:         state_d = KEY_WAIT_FIRST;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_WAIT_FIRST;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             kick_i,
  output logic             armed_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign ovf_o = armed_q && tick_i && (cnt_q == CNT_MAX) && !kick_i;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (kick_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (ovf_o) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (armed_q && tick_i) begin
      cnt_d   = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign armed_o = armed_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int PULSE_LEN = 98
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic inhibit_i,
  output logic pulse_o
);
  localparam int LW = $clog2(PULSE_LEN + 1);

  logic [LW-1:0] remain_q, remain_d;

  always_comb begin
    remain_d = remain_q;
    if (fire_i && !inhibit_i)  remain_d = LW'(PULSE_LEN);
    else if (remain_q != '0)   remain_d = remain_q - LW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) remain_q <= '0;
    else         remain_q <= remain_d;
  end

  assign pulse_o = (remain_q != '0);
endmodule

// File: rtl/armed_watchdog.sv
module armed_watchdog #(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter int                CNT_W       = 14,
  parameter int                PULSE_LEN   = 98,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] KEY_ADDR    = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST   = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND  = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mc_en_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              rst_out_inhibit_i,
  output logic              rst_out_o
);
  logic             rst_n_sync;
  logic             kick;
  logic             ovf;
  logic             armed;
  logic [CNT_W-1:0] cnt;

  wdg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  wdg_unlock #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .KEY_ADDR  (KEY_ADDR),
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
  ) u_unlock (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .wr_i   (bus_wr_i),
    .addr_i (bus_addr_i),
    .data_i (bus_wdata_i),
    .clear_i(ovf),
    .kick_o (kick)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .tick_i (mc_en_i),
    .kick_i (kick),
    .armed_o(armed),
    .cnt_o  (cnt),
    .ovf_o  (ovf)
  );

  wdg_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .fire_i   (ovf),
    .inhibit_i(rst_out_inhibit_i),
    .pulse_o  (rst_out_o)
  );
endmodule

// File: rtl/armed_watchdog_chk.sv
module armed_watchdog_chk #(
  parameter int CNT_W     = 14,
  parameter int PULSE_LEN = 98
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             mc_en_i,
  input logic             kick,
  input logic             ovf,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic             inhibit,
  input logic             rst_out
);
  localparam int               HW      = $clog2(PULSE_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [HW-1:0] hi_len_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       hi_len_q <= '0;
    else if (rst_out) hi_len_q <= hi_len_q + HW'(1);
    else              hi_len_q <= '0;
  end

  // R2: the active flag only rises after an accepted key
  p_arm_by_key_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(armed) |-> $past(kick));

  // R3: the count steps by one per enabled machine cycle
  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (armed && mc_en_i && !kick && cnt != CNT_TOP) |=> (cnt == CNT_W'($past(cnt) + 1)));

  // R5: every pulse lasts the configured number of clocks
  p_pulse_len_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(rst_out) |-> (hi_len_q == HW'(PULSE_LEN)));

  // R6: expiry leaves the watchdog inactive with a cleared count
  p_expiry_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    ovf |=> (!armed && cnt == '0));

  // R7: an accepted key leaves the watchdog active at zero
  p_kick_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    kick |=> (armed && cnt == '0));

  // R8: no enable, no movement
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (armed && !mc_en_i && !kick) |=> (armed && $stable(cnt)));

  // R9: a pulse starts only after an uninhibited expiry
  p_pulse_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rst_out) |-> $past(ovf && !inhibit));
endmodule

bind armed_watchdog armed_watchdog_chk #(
  .CNT_W    (CNT_W),
  .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk_i  (clk_i),
  .rst_n  (rst_n_sync),
  .mc_en_i(mc_en_i),
  .kick   (kick),
  .ovf    (ovf),
  .armed  (armed),
  .cnt    (cnt),
  .inhibit(rst_out_inhibit_i),
  .rst_out(rst_out_o)
);

// File: tb/tb_armed_watchdog.sv
module tb_armed_watchdog;
  localparam int EXPIRY   = 16384;  // 2**14 enabled cycles
  localparam int PULSE    = 98;
  localparam int QUIET    = 16500;
  localparam int WD_LIMIT = 195000;

  logic       clk;
  logic       rst_n;
  logic       mc_en;
  logic       wr;
  logic [7:0] addr;
  logic [7:0] wdata;
  logic       inhibit;
  logic       rst_out;

  int total;
  int bad;

  armed_watchdog dut (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .mc_en_i          (mc_en),
    .bus_wr_i         (wr),
    .bus_addr_i       (addr),
    .bus_wdata_i      (wdata),
    .rst_out_inhibit_i(inhibit),
    .rst_out_o        (rst_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; addr = 8'h00; wdata = 8'h00;
  endtask

  task automatic write_key();
    bus_write(8'hA6, 8'h1E);
    bus_write(8'hA6, 8'hE1);
  endtask

  // Counts clock edges from the current negedge until rst_out is seen high.
  task automatic edges_to_rise(output int n);
    n = 0;
    while (n < EXPIRY + 200) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (rst_out) return;
    end
  endtask

  task automatic high_width(output int w);
    w = 1;
    forever begin
      @(negedge clk);
      if (!rst_out) return;
      w++;
    end
  endtask

  task automatic quiet_window(input int cycles, output int highs);
    highs = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (rst_out) highs++;
    end
  endtask

  task automatic t_reset();
    int h;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_eq("R1", "rst_out during reset", int'(rst_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    quiet_window(QUIET, h);
    check_eq("R1", "pulse cycles without key", h, 0);
  endtask

  task automatic t_arm_fire();
    int n, w;
    write_key();
    edges_to_rise(n);
    check_eq("R3", "edges from key to pulse", n, EXPIRY);
    high_width(w);
    check_eq("R5", "pulse width", w, PULSE);
  endtask

  task automatic t_after_expiry();
    int h;
    quiet_window(QUIET, h);
    check_eq("R6", "pulse cycles after expiry", h, 0);
  endtask

  task automatic t_abort();
    int h, n;
    bus_write(8'hA6, 8'h1E);
    bus_write(8'hA6, 8'h55);
    bus_write(8'hA6, 8'hE1);
    quiet_window(QUIET, h);
    check_eq("R4", "pulse cycles after broken key", h, 0);
    bus_write(8'hA6, 8'h1E);
    bus_write(8'h10, 8'hE1);
    bus_write(8'hA6, 8'hE1);
    edges_to_rise(n);
    check_eq("R2", "key with foreign write between", n, EXPIRY);
    repeat (PULSE + 20) @(negedge clk);
  endtask

  task automatic t_restart();
    int h, n;
    write_key();
    quiet_window(2000, h);
    check_eq("R7", "no pulse before restart", h, 0);
    write_key();
    edges_to_rise(n);
    check_eq("R7", "edges from restart to pulse", n, EXPIRY);
    repeat (PULSE + 20) @(negedge clk);
  endtask

  task automatic t_inhibit();
    int h;
    inhibit = 1'b1;
    write_key();
    quiet_window(QUIET, h);
    check_eq("R9", "pulse cycles while inhibited", h, 0);
    inhibit = 1'b0;
  endtask

  task automatic t_mc_gate();
    int h, n;
    mc_en = 1'b0;
    write_key();
    quiet_window(500, h);
    check_eq("R8", "pulse cycles with enable low", h, 0);
    mc_en = 1'b1;
    edges_to_rise(n);
    check_eq("R8", "edges after enable returns", n, EXPIRY);
    repeat (PULSE + 20) @(negedge clk);
  endtask

  task automatic t_hw_reset();
    int h;
    write_key();
    repeat (1000) @(negedge clk);
    do_reset();
    quiet_window(QUIET, h);
    check_eq("R10", "pulse cycles after reset of active watchdog", h, 0);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; mc_en = 1'b1; wr = 1'b0; addr = 8'h00; wdata = 8'h00; inhibit = 1'b0;
    t_reset();
    t_arm_fire();
    t_after_expiry();
    t_abort();
    t_restart();
    t_inhibit();
    t_mc_gate();
    t_hw_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule